// File: doc/BRIEF.md
# Time-Shared Complex Correlator Cell

This cell cross-correlates two streams of 2-bit complex samples. On every accepted sample it multiplies the sample from stream A by the complex conjugate of the sample from stream B. It then folds the product into one of `NUM_ACC` running sums kept in a small RAM. An address counter steps through the RAM once per accepted sample, so a single multiplier serves `NUM_ACC` interleaved products, such as channels or baselines. Each product keeps its own 16+16-bit sum.

A full sweep of all addresses is one pass, and `integ_len` passes make one integration. On the first pass the product replaces the stored word, so the accumulator clears itself with no separate cycle. On the last pass the finished sum leaves on a 32-bit result stream together with its RAM address. Sums that leave the signed 16-bit range are clamped, and a sticky flag records that this happened.

Samples enter on a valid/ready handshake: a sample is taken on a rising edge where `in_valid` and `in_ready` are both high. Results leave on a valid/ready handshake. While a result is held with `out_ready` low, the whole cell stalls and `in_ready` is low. `in_ready` follows `out_ready` in the same cycle. Once `out_valid` is high, it and the result stay stable until they are taken.

Top module: `xcm_corr_cell`

## Requirements
- R1: After reset, `out_valid` and `ovf_flag` are 0 and `in_ready` is 1. The first accepted sample goes to address 0 at the start of an integration.
- R2: `in_a` and `in_b` carry the real part in bits [3:2] and the imaginary part in bits [1:0], each in two's complement. The product has real part ArBr+AiBi and imaginary part AiBr−ArBi. With `integ_len` = 1, every result equals the product of its own sample.
- R3: The k-th accepted sample since reset updates accumulator k mod `NUM_ACC`, and `out_addr` names that accumulator. `out_data` holds the real sum in [31:16] and the imaginary sum in [15:0].
- R4: With `integ_len` = L, each accumulator delivers one result per integration: the sum of its L products. A value of 0 acts as 1. `integ_len` may change only at an integration boundary.
- R5: The first pass of an integration overwrites the stored sum, so no value from an earlier integration reaches a result.
- R6: A sum above 32767 or below −32768 is clamped to that limit, and `ovf_flag` then goes high and stays high until reset.
- R7: `out_valid` goes high at the rising edge after the edge that accepted the last contributing sample.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low, no sample is accepted, and `out_data` and `out_addr` hold their values.
- R9: With `NUM_ACC` = 1, back-to-back samples into the same accumulator give correct sums: a sum that is still being written is forwarded to the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| integ_len | input | PASS_W | Passes per integration (0 treated as 1) |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Cell can take a sample pair |
| in_a | input | 4 | Stream A sample {re[1:0], im[1:0]} |
| in_b | input | 4 | Stream B sample {re[1:0], im[1:0]}, conjugated |
| out_valid | output | 1 | Finished sum present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | {real sum, imaginary sum}, 16 bits each |
| out_addr | output | ADDR_W | Accumulator address of the result |
| ovf_flag | output | 1 | Sticky saturation flag |

## Verification
A sample taken at one rising edge is registered together with the RAM read of its accumulator. The read-modify-write and the result register both load at the next edge. So `out_valid` and `ovf_flag` are due exactly one edge after the edge that accepts the final contributing sample. `in_ready` responds to `out_ready` within the same cycle. The bench drives inputs on falling edges and samples outputs 2 ns before each rising edge. The latency check looks for `out_valid` low one cycle after acceptance and high the cycle after that. A reference model updated at each acceptance queues the expected results, and every completed handshake is compared against that queue in order.

// File: rtl/xcm_pkg.sv
package xcm_pkg;

  // Position of the current pass within an integration
  typedef struct packed {
    logic first;
    logic last;
  } pass_pos_t;

  // Address width that also works for a single-entry RAM
  function automatic int unsigned addr_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/xcm_cmul.sv
module xcm_cmul #(
  parameter int unsigned SW = 2,
  parameter int unsigned PW = 5
) (
  input  logic [2*SW-1:0]       a,
  input  logic [2*SW-1:0]       b,
  output logic signed [PW-1:0]  p_re,
  output logic signed [PW-1:0]  p_im
);
  logic signed [PW-1:0] ar, ai, br, bi;

  always_comb begin
    ar = {{(PW-SW){a[2*SW-1]}}, a[2*SW-1:SW]};
    ai = {{(PW-SW){a[SW-1]}},   a[SW-1:0]};
    br = {{(PW-SW){b[2*SW-1]}}, b[2*SW-1:SW]};
    bi = {{(PW-SW){b[SW-1]}},   b[SW-1:0]};
    // a * conj(b)
    p_re = ar * br + ai * bi;
    p_im = ai * br - ar * bi;
  end
endmodule

// File: rtl/xcm_seq.sv
module xcm_seq import xcm_pkg::*; #(
  parameter int unsigned NUM_ACC = 8,
  parameter int unsigned PASS_W  = 16,
  parameter int unsigned ADDR_W  = addr_bits(NUM_ACC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [PASS_W-1:0] passes,
  output logic [ADDR_W-1:0] addr,
  output pass_pos_t         pos
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_ACC - 1);

  logic [ADDR_W-1:0] addr_q;
  logic [PASS_W-1:0] pass_q;
  logic [PASS_W-1:0] len_m1;
  logic              wrap;

  always_comb begin
    len_m1    = (passes == '0) ? '0 : passes - PASS_W'(1);
    pos.first = (pass_q == '0);
    pos.last  = (pass_q >= len_m1);
    wrap      = (addr_q == LAST_ADDR);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      pass_q <= '0;
    end else if (step) begin
      addr_q <= wrap ? '0 : addr_q + ADDR_W'(1);
      if (wrap) pass_q <= pos.last ? '0 : pass_q + PASS_W'(1);
    end
  end

  assign addr = addr_q;

  assert_addr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_q <= LAST_ADDR);

  assert_addr_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step && wrap |=> addr_q == '0);

  assert_pass_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step && wrap && pos.last |=> pos.first);
endmodule

// File: rtl/xcm_sat_lane.sv
module xcm_sat_lane #(
  parameter int unsigned PW = 5,
  parameter int unsigned AW = 16
) (
  input  logic                 first,
  input  logic [AW-1:0]        old,
  input  logic signed [PW-1:0] prod,
  output logic [AW-1:0]        sum,
  output logic                 ovf
);
  logic [AW:0] ext_old, ext_p, raw;

  always_comb begin
    ext_old = {old[AW-1], old};
    ext_p   = {{(AW+1-PW){prod[PW-1]}}, prod};
    raw     = first ? ext_p : ext_old + ext_p;
    ovf     = (raw[AW] != raw[AW-1]);
    if (ovf) sum = raw[AW] ? {1'b1, {(AW-1){1'b0}}} : {1'b0, {(AW-1){1'b1}}};
    else     sum = raw[AW-1:0];
  end
endmodule

// File: rtl/xcm_acc_ram.sv
module xcm_acc_ram #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 3,
  parameter int unsigned DW    = 32
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    // a write landing on the address being read is forwarded
    if (rd_en) rd_q <= (wr_en && wr_addr == rd_addr) ? wr_data : mem[rd_addr];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/xcm_corr_cell.sv
module xcm_corr_cell import xcm_pkg::*; #(
  parameter int unsigned SAMPLE_W = 2,
  parameter int unsigned PROD_W   = 5,
  parameter int unsigned ACC_W    = 16,
  parameter int unsigned NUM_ACC  = 8,
  parameter int unsigned PASS_W   = 16,
  localparam int unsigned ADDR_W  = addr_bits(NUM_ACC),
  localparam int unsigned WORD_W  = 2 * ACC_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PASS_W-1:0]     integ_len,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [2*SAMPLE_W-1:0] in_a,
  input  logic [2*SAMPLE_W-1:0] in_b,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [WORD_W-1:0]     out_data,
  output logic [ADDR_W-1:0]     out_addr,
  output logic                  ovf_flag
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_ACC - 1);

  logic adv, take;
  logic [ADDR_W-1:0] cur_addr;
  pass_pos_t cur_pos;
  logic signed [PROD_W-1:0] prod_c [2];

  // stage 1: product and address waiting for the RAM word
  logic s1_valid;
  logic [ADDR_W-1:0] s1_addr;
  pass_pos_t s1_pos;
  logic signed [PROD_W-1:0] s1_prod [2];

  logic [WORD_W-1:0] rd_word, new_word;
  logic [1:0] lane_ovf;
  logic wr_en;

  logic out_valid_q, ovf_q;
  logic [WORD_W-1:0] out_data_q;
  logic [ADDR_W-1:0] out_addr_q;

  assign adv      = !out_valid_q || out_ready;
  assign take     = in_valid && adv;
  assign in_ready = adv;
  assign wr_en    = s1_valid && adv;

  xcm_seq #(.NUM_ACC(NUM_ACC), .PASS_W(PASS_W), .ADDR_W(ADDR_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .step(take), .passes(integ_len),
    .addr(cur_addr), .pos(cur_pos)
  );

  xcm_cmul #(.SW(SAMPLE_W), .PW(PROD_W)) cmul_i (
    .a(in_a), .b(in_b), .p_re(prod_c[1]), .p_im(prod_c[0])
  );

  always_ff @(posedge clk) begin
    if (!rst_n) s1_valid <= 1'b0;
    else if (adv) s1_valid <= take;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      s1_addr    <= cur_addr;
      s1_pos     <= cur_pos;
      s1_prod[0] <= prod_c[0];
      s1_prod[1] <= prod_c[1];
    end
  end

  xcm_acc_ram #(.DEPTH(NUM_ACC), .AW(ADDR_W), .DW(WORD_W)) ram_i (
    .clk(clk), .rd_en(take), .rd_addr(cur_addr), .rd_data(rd_word),
    .wr_en(wr_en), .wr_addr(s1_addr), .wr_data(new_word)
  );

  // lane 1 = real (upper half), lane 0 = imaginary (lower half)
  for (genvar g = 0; g < 2; g++) begin : g_lane
    xcm_sat_lane #(.PW(PROD_W), .AW(ACC_W)) lane_i (
      .first(s1_pos.first),
      .old(rd_word[g*ACC_W +: ACC_W]),
      .prod(s1_prod[g]),
      .sum(new_word[g*ACC_W +: ACC_W]),
      .ovf(lane_ovf[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      ovf_q       <= 1'b0;
    end else begin
      if (adv) out_valid_q <= s1_valid && s1_pos.last;
      if (wr_en && (|lane_ovf)) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (adv && s1_valid && s1_pos.last) begin
      out_data_q <= new_word;
      out_addr_q <= s1_addr;
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
  assign out_addr  = out_addr_q;
  assign ovf_flag  = ovf_q;

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_addr));

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  assert_out_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_addr <= LAST_ADDR);

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(s1_valid && s1_pos.last));
endmodule

// File: tb/xcm_corr_cell_tb.sv
`timescale 1ns/1ps
module xcm_corr_cell_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;
  logic rst_n;

  logic v0, rdy0, ov0, ordy0, ovf0;
  logic [3:0] a0, b0;
  logic [15:0] len0;
  logic [31:0] od0;
  logic [2:0] oa0;

  logic v1, rdy1, ov1, ordy1, ovf1;
  logic [3:0] a1, b1;
  logic [15:0] len1;
  logic [31:0] od1;
  logic [0:0] oa1;

  xcm_corr_cell #(.NUM_ACC(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .integ_len(len0), .in_valid(v0), .in_ready(rdy0),
    .in_a(a0), .in_b(b0), .out_valid(ov0), .out_ready(ordy0), .out_data(od0),
    .out_addr(oa0), .ovf_flag(ovf0));

  xcm_corr_cell #(.NUM_ACC(1)) dut_fwd_i (
    .clk(clk), .rst_n(rst_n), .integ_len(len1), .in_valid(v1), .in_ready(rdy1),
    .in_a(a1), .in_b(b1), .out_valid(ov1), .out_ready(ordy1), .out_data(od1),
    .out_addr(oa1), .ovf_flag(ovf1));

  int n_tests = 0, n_fail = 0;
  string cur_req = "R2";
  logic [39:0] q0[$], q1[$];
  int m_re[2][8], m_im[2][8], m_addr[2], m_pass[2];
  logic [31:0] last_od1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int sx2(input logic [1:0] v);
    return v[1] ? int'(v) - 4 : int'(v);
  endfunction

  function automatic int clamp16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // Reference model, updated when a sample is accepted
  task automatic model_accept(input int d, input logic [3:0] a, input logic [3:0] b,
                              input int passes, input int nacc);
    int ar, ai, br, bi, pr, pi, len, ad, re, im;
    ar = sx2(a[3:2]); ai = sx2(a[1:0]); br = sx2(b[3:2]); bi = sx2(b[1:0]);
    pr = ar * br + ai * bi;
    pi = ai * br - ar * bi;
    len = (passes == 0) ? 1 : passes;
    ad = m_addr[d];
    if (m_pass[d] == 0) begin re = pr; im = pi; end
    else begin re = clamp16(m_re[d][ad] + pr); im = clamp16(m_im[d][ad] + pi); end
    m_re[d][ad] = re; m_im[d][ad] = im;
    if (m_pass[d] == len - 1) begin
      if (d == 0) q0.push_back({8'(ad), 16'(re), 16'(im)});
      else        q1.push_back({8'(ad), 16'(re), 16'(im)});
    end
    m_addr[d] = (ad + 1 == nacc) ? 0 : ad + 1;
    if (m_addr[d] == 0) m_pass[d] = (m_pass[d] == len - 1) ? 0 : m_pass[d] + 1;
  endtask

  // Result monitors, 2 ns before each rising edge
  always begin : mon0
    logic [39:0] e;
    @(negedge clk); #2;
    if (rst_n && ov0 && ordy0) begin
      if (q0.size() == 0) chk(1'b0, cur_req, "unexpected result", od0, 0);
      else begin
        e = q0.pop_front();
        chk(od0 == e[31:0], cur_req, "out_data", od0, e[31:0]);
        chk(8'(oa0) == e[39:32], "R3", "out_addr", oa0, e[39:32]);
      end
    end
  end

  always begin : mon1
    logic [39:0] e;
    @(negedge clk); #2;
    if (rst_n && ov1 && ordy1) begin
      last_od1 = od1;
      if (q1.size() == 0) chk(1'b0, cur_req, "unexpected result", od1, 0);
      else begin
        e = q1.pop_front();
        chk(od1 == e[31:0], cur_req, "out_data", od1, e[31:0]);
        chk(8'(oa1) == e[39:32], "R3", "out_addr", oa1, e[39:32]);
      end
    end
  end

  task automatic push0(input logic [3:0] a, input logic [3:0] b);
    @(negedge clk); a0 = a; b0 = b; v0 = 1'b1; #2;
    while (!rdy0) begin @(negedge clk); #2; end
    model_accept(0, a, b, int'(len0), 8);
    @(posedge clk); #1;
  endtask

  task automatic push1(input logic [3:0] a, input logic [3:0] b);
    @(negedge clk); a1 = a; b1 = b; v1 = 1'b1; #2;
    while (!rdy1) begin @(negedge clk); #2; end
    model_accept(1, a, b, int'(len1), 1);
    @(posedge clk); #1;
  endtask

  task automatic drain(input string req);
    @(negedge clk); v0 = 1'b0; v1 = 1'b0; ordy0 = 1'b1; ordy1 = 1'b1;
    repeat (6) @(negedge clk);
    #2;
    chk(q0.size() == 0, req, "results missing (main)", q0.size(), 0);
    chk(q1.size() == 0, req, "results missing (fwd)", q1.size(), 0);
  endtask

  task automatic t_reset();
    @(negedge clk); #2;
    chk(ov0 == 1'b0, "R1", "out_valid after reset", ov0, 0);
    chk(ovf0 == 1'b0, "R1", "ovf_flag after reset", ovf0, 0);
    chk(rdy0 == 1'b1, "R1", "in_ready after reset", rdy0, 1);
    chk(ov1 == 1'b0, "R1", "fwd out_valid after reset", ov1, 0);
  endtask

  task automatic t_latency();
    cur_req = "R7"; len0 = 16'd1;
    push0(4'b0101, 4'b0111);            // (1+1j)*conj(1-1j) = 0+2j
    @(negedge clk); v0 = 1'b0; #2;
    chk(ov0 == 1'b0, "R7", "out_valid one cycle after accept", ov0, 0);
    @(negedge clk); #2;
    chk(ov0 == 1'b1, "R7", "out_valid two cycles after accept", ov0, 1);
    chk(od0 == 32'h0000_0002, "R2", "first product", od0, 32'h0000_0002);
    chk(oa0 == 3'd0, "R1", "first address", oa0, 0);
    for (int i = 0; i < 7; i++) push0(4'($urandom), 4'($urandom));
    drain("R7");
  endtask

  task automatic t_product();
    cur_req = "R2"; len0 = 16'd1;
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) push0(4'(a), 4'(b));
    drain("R2");
  endtask

  task automatic t_len_zero();
    cur_req = "R4"; len0 = 16'd0;
    for (int i = 0; i < 8; i++) push0(4'($urandom), 4'($urandom));
    drain("R4");
  endtask

  task automatic t_integrate();
    cur_req = "R4"; len0 = 16'd4;
    for (int i = 0; i < 32; i++) push0(4'($urandom), 4'($urandom));
    drain("R4");
    cur_req = "R5";                     // A = 0: any old sum would show
    for (int i = 0; i < 32; i++) push0(4'b0000, 4'($urandom));
    drain("R5");
    cur_req = "R4"; len0 = 16'd3;
    for (int i = 0; i < 24; i++) push0(4'($urandom), 4'($urandom));
    drain("R4");
  endtask

  task automatic t_backpressure();
    logic [31:0] held_d;
    logic [2:0] held_a;
    cur_req = "R8"; len0 = 16'd1;
    @(negedge clk); ordy0 = 1'b0;
    push0(4'b0101, 4'b0101);
    push0(4'b1010, 4'b0101);
    @(negedge clk); a0 = 4'b0111; b0 = 4'b0111; v0 = 1'b1; #2;   // must not be taken
    chk(ov0 == 1'b1, "R8", "out_valid while stalled", ov0, 1);
    chk(rdy0 == 1'b0, "R8", "in_ready while stalled", rdy0, 0);
    held_d = od0; held_a = oa0;
    repeat (3) @(negedge clk);
    #2;
    chk(od0 == held_d, "R8", "out_data held", od0, held_d);
    chk(oa0 == held_a, "R8", "out_addr held", oa0, held_a);
    chk(rdy0 == 1'b0, "R8", "in_ready still low", rdy0, 0);
    @(negedge clk); v0 = 1'b0; ordy0 = 1'b1;
    drain("R8");
    for (int i = 0; i < 6; i++) push0(4'($urandom), 4'($urandom));
    drain("R8");
  endtask

  task automatic t_forward();
    cur_req = "R9"; len1 = 16'd3;
    for (int i = 0; i < 30; i++) push1(4'($urandom), 4'($urandom));
    drain("R9");
    len1 = 16'd1;
    for (int i = 0; i < 5; i++) push1(4'($urandom), 4'($urandom));
    drain("R9");
  endtask

  task automatic t_saturate();
    cur_req = "R6";
    chk(ovf1 == 1'b0, "R6", "ovf_flag before saturation", ovf1, 0);
    len1 = 16'd5000;                     // +8 per sample -> clamp at 32767
    for (int i = 0; i < 5000; i++) push1(4'b1010, 4'b1010);
    drain("R6");
    chk(last_od1 == 32'h7FFF_0000, "R6", "positive clamp", last_od1, 32'h7FFF_0000);
    chk(ovf1 == 1'b1, "R6", "ovf_flag set", ovf1, 1);
    chk(ovf0 == 1'b0, "R6", "other cell ovf_flag", ovf0, 0);
    len1 = 16'd9000;                     // -4 per sample -> clamp at -32768
    for (int i = 0; i < 9000; i++) push1(4'b1010, 4'b0101);
    drain("R6");
    chk(last_od1 == 32'h8000_0000, "R6", "negative clamp", last_od1, 32'h8000_0000);
    chk(ovf1 == 1'b1, "R6", "ovf_flag sticky", ovf1, 1);
  endtask

  initial begin : watchdog
    #1200000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    v0 = 1'b0; a0 = '0; b0 = '0; ordy0 = 1'b1; len0 = 16'd1;
    v1 = 1'b0; a1 = '0; b1 = '0; ordy1 = 1'b1; len1 = 16'd1;
    last_od1 = '0;
    for (int d = 0; d < 2; d++) begin m_addr[d] = 0; m_pass[d] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latency();
    t_product();
    t_len_zero();
    t_integrate();
    t_backpressure();
    t_forward();
    t_saturate();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule